// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM. A host puts a word address on `addr_i` and pulses `start_i`. The block then raises chip select and shifts out a read command followed by the address. It clocks sixteen data bits back in from the device's data-out line, runs a fixed closing sequence, and reports the word together with a single-cycle `done_o` strobe.

All serial timing comes from a phase timer that counts system clock cycles. Two minimum times set the pace. The setup time is the time data-in must be stable before a rising serial clock. The level time is how long the serial clock must rest at each level, and it is much longer than the setup time. Both times are given in nanoseconds together with the system clock frequency, and they are converted to cycle counts with ceiling division. A read closes in a fixed way: chip select and data-in fall together, one more full serial clock pulse is sent with chip select low, and only then is the word reported.

Top module: `mw_word_reader`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `ee_cs_o`, `ee_sk_o`, `ee_di_o` and `done_o` are all low.
- R2: A start request taken while idle raises `busy_o` and `ee_cs_o` one cycle later. Chip select then stays high through the command, address and data phases.
- R3: The outgoing bit stream is the 3-bit read opcode `110` followed by the 6-bit word address, each field most significant bit first. The device captures each bit on a rising edge of `ee_sk_o`.
- R4: At every rising edge of `ee_sk_o`, `ee_di_o` and `ee_cs_o` have been stable for at least SETUP_TICKS cycles. After the last address bit, `ee_di_o` is low for at least SETUP_TICKS cycles before the first read clock.
- R5: Each low level of `ee_sk_o` between two rising edges lasts at least LEVEL_TICKS cycles.
- R6: Exactly 16 data bits are read, most significant first. Each bit is sampled from `ee_do_i` in the last cycle of a clock-high level. The assembled word appears on `word_o` when `done_o` is high.
- R7: At the end of a read, `ee_cs_o` and `ee_di_o` fall while `ee_sk_o` is low. Exactly one further `ee_sk_o` pulse follows with chip select low, and then `done_o` is raised.
- R8: `done_o` is high for exactly one cycle per read, and `busy_o` falls in the following cycle.
- R9: A start request while `busy_o` is high, including the cycle in which `done_o` is high, is ignored. The address in use does not change, and no second read follows.
- R10: SETUP_TICKS and LEVEL_TICKS are the ceiling of time_ns * CLK_FREQ_HZ / 1e9, and never less than 1. Every high level of `ee_sk_o` lasts exactly LEVEL_TICKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read request, taken only while idle |
| addr_i | input | ADDR_BITS | Word address, latched with the request |
| busy_o | output | 1 | High from the accepted request through the done cycle |
| done_o | output | 1 | One-cycle strobe, read word valid |
| word_o | output | DATA_BITS | Word read from the device |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | EEPROM serial data in (driven by this block) |
| ee_do_i | input | 1 | EEPROM serial data out (sampled by this block) |

## Verification
Two events can fall in the same cycle: a host start request and the done strobe. The done cycle is the last cycle of the busy window and the first in which a host could launch the next read. To provoke this, the bench holds `start_i` high from the accepted request through the cycle in which `done_o` is seen, and changes `addr_i` partway through. The collision is judged correct when the returned word and the address the responder captured both belong to the first address, and `busy_o` is low on the two cycles after done with no new chip select.

// File: rtl/mw_reader_pkg.sv
package mw_reader_pkg;

  localparam int unsigned OP_BITS = 3;
  localparam logic [OP_BITS-1:0] READ_OP = 3'b110;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLKH,
    ST_CLKL,
    ST_HOLD,
    ST_RDH,
    ST_RDL,
    ST_TDROP,
    ST_TH,
    ST_TL,
    ST_FIN
  } mw_state_e;

  // Cycles covering a minimum time, rounded up, never below one.
  function automatic int unsigned ceil_ticks(input longint unsigned t_ns,
                                             input longint unsigned hz);
    longint unsigned prod;
    longint unsigned q;
    prod = t_ns * hz;
    q    = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (q == 0) q = 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = len_i - TW'(1);
    else        cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R10
  timer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (len_i != '0));

endmodule

// File: rtl/mw_bit_shifter.sv
module mw_bit_shifter #(
  parameter int unsigned OUT_BITS  = 9,
  parameter int unsigned DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_cmd_i,
  input  logic [OUT_BITS-1:0]  cmd_i,
  input  logic                 shift_i,
  input  logic                 sample_i,
  input  logic                 clr_cnt_i,
  input  logic                 do_i,
  output logic                 msb_o,
  output logic                 last_out_o,
  output logic                 all_in_o,
  output logic [DATA_BITS-1:0] word_o
);

  localparam int unsigned MAXB  = (OUT_BITS > DATA_BITS) ? OUT_BITS : DATA_BITS;
  localparam int unsigned CNT_W = $clog2(MAXB + 1);

  logic [OUT_BITS-1:0]  cmd_q, cmd_d;
  logic [DATA_BITS-1:0] word_q, word_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 cmd_en, word_en, cnt_en;

  always_comb begin
    cmd_en  = load_cmd_i || shift_i;
    cmd_d   = load_cmd_i ? cmd_i : {cmd_q[OUT_BITS-2:0], 1'b0};
    word_en = load_cmd_i || sample_i;
    word_d  = load_cmd_i ? '0 : {word_q[DATA_BITS-2:0], do_i};
    cnt_en  = load_cmd_i || clr_cnt_i || shift_i || sample_i;
    cnt_d   = (load_cmd_i || clr_cnt_i) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (cmd_en)  cmd_q  <= cmd_d;
      if (word_en) word_q <= word_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign msb_o      = cmd_q[OUT_BITS-1];
  assign last_out_o = (cnt_q == CNT_W'(OUT_BITS - 1));
  assign all_in_o   = (cnt_q == CNT_W'(DATA_BITS));
  assign word_o     = word_q;

  // R6
  sample_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |-> (cnt_q < CNT_W'(DATA_BITS)));

  // R3
  shift_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (cnt_q < CNT_W'(OUT_BITS - 1)));

endmodule

// File: rtl/mw_read_fsm.sv
module mw_read_fsm
  import mw_reader_pkg::*;
#(
  parameter int unsigned TW          = 8,
  parameter int unsigned SETUP_TICKS = 3,
  parameter int unsigned LEVEL_TICKS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          tmr_zero_i,
  input  logic          last_out_i,
  input  logic          all_in_i,
  input  logic          cmd_msb_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_len_o,
  output logic          load_cmd_o,
  output logic          shift_o,
  output logic          sample_o,
  output logic          clr_cnt_o,
  output logic          cs_o,
  output logic          sk_o,
  output logic          di_o,
  output logic          busy_o,
  output logic          done_o
);

  localparam logic [TW-1:0] LEN_SETUP = TW'(SETUP_TICKS);
  localparam logic [TW-1:0] LEN_LEVEL = TW'(LEVEL_TICKS);

  mw_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_len_o  = LEN_LEVEL;
    load_cmd_o = 1'b0;
    shift_o    = 1'b0;
    sample_o   = 1'b0;
    clr_cnt_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d    = ST_SETUP;
        tmr_load_o = 1'b1;
        tmr_len_o  = LEN_SETUP;
        load_cmd_o = 1'b1;
      end
      ST_SETUP: if (tmr_zero_i) begin
        state_d    = ST_CLKH;
        tmr_load_o = 1'b1;
      end
      ST_CLKH: if (tmr_zero_i) begin
        state_d    = ST_CLKL;
        tmr_load_o = 1'b1;
      end
      ST_CLKL: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        tmr_len_o  = LEN_SETUP;
        if (last_out_i) begin
          state_d   = ST_HOLD;
          clr_cnt_o = 1'b1;
        end else begin
          state_d = ST_SETUP;
          shift_o = 1'b1;
        end
      end
      ST_HOLD: if (tmr_zero_i) begin
        state_d    = ST_RDH;
        tmr_load_o = 1'b1;
      end
      ST_RDH: if (tmr_zero_i) begin
        state_d    = ST_RDL;
        tmr_load_o = 1'b1;
        sample_o   = 1'b1;
      end
      ST_RDL: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        if (all_in_i) begin
          state_d   = ST_TDROP;
          tmr_len_o = LEN_SETUP;
        end else begin
          state_d = ST_RDH;
        end
      end
      ST_TDROP: if (tmr_zero_i) begin
        state_d    = ST_TH;
        tmr_load_o = 1'b1;
      end
      ST_TH: if (tmr_zero_i) begin
        state_d    = ST_TL;
        tmr_load_o = 1'b1;
      end
      ST_TL: if (tmr_zero_i) state_d = ST_FIN;
      ST_FIN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    cs_o   = (state_q == ST_SETUP) || (state_q == ST_CLKH) || (state_q == ST_CLKL) ||
             (state_q == ST_HOLD)  || (state_q == ST_RDH)  || (state_q == ST_RDL);
    sk_o   = (state_q == ST_CLKH) || (state_q == ST_RDH) || (state_q == ST_TH);
    di_o   = cmd_msb_i && ((state_q == ST_SETUP) || (state_q == ST_CLKH) ||
                           (state_q == ST_CLKL));
    busy_o = (state_q != ST_IDLE);
    done_o = (state_q == ST_FIN);
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!cs_o && !sk_o && !di_o && !done_o));

  // R2
  start_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && cs_o));

  // R4
  sk_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk_o) |-> ($stable(di_o) && $stable(cs_o)));

  // R7
  cs_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_o) |-> (!sk_o && !di_o));

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader
  import mw_reader_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 125_000_000,
  parameter int unsigned SETUP_NS    = 400,
  parameter int unsigned LEVEL_NS    = 9000,
  parameter int unsigned ADDR_BITS   = 6,
  parameter int unsigned DATA_BITS   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] word_o,
  output logic                 ee_cs_o,
  output logic                 ee_sk_o,
  output logic                 ee_di_o,
  input  logic                 ee_do_i
);

  localparam int unsigned SETUP_TICKS = ceil_ticks(longint'(SETUP_NS), longint'(CLK_FREQ_HZ));
  localparam int unsigned LEVEL_TICKS = ceil_ticks(longint'(LEVEL_NS), longint'(CLK_FREQ_HZ));
  localparam int unsigned MAX_TICKS   = (SETUP_TICKS > LEVEL_TICKS) ? SETUP_TICKS : LEVEL_TICKS;
  localparam int unsigned TW          = $clog2(MAX_TICKS + 1);
  localparam int unsigned OUT_BITS    = OP_BITS + ADDR_BITS;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_len;
  logic          load_cmd, shift_bit, sample_bit, clr_cnt;
  logic          cmd_msb, last_out, all_in;

  mw_phase_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .zero_o (tmr_zero)
  );

  mw_bit_shifter #(.OUT_BITS(OUT_BITS), .DATA_BITS(DATA_BITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load_cmd_i (load_cmd),
    .cmd_i      ({READ_OP, addr_i}),
    .shift_i    (shift_bit),
    .sample_i   (sample_bit),
    .clr_cnt_i  (clr_cnt),
    .do_i       (ee_do_i),
    .msb_o      (cmd_msb),
    .last_out_o (last_out),
    .all_in_o   (all_in),
    .word_o     (word_o)
  );

  mw_read_fsm #(.TW(TW), .SETUP_TICKS(SETUP_TICKS), .LEVEL_TICKS(LEVEL_TICKS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start_i    (start_i),
    .tmr_zero_i (tmr_zero),
    .last_out_i (last_out),
    .all_in_i   (all_in),
    .cmd_msb_i  (cmd_msb),
    .tmr_load_o (tmr_load),
    .tmr_len_o  (tmr_len),
    .load_cmd_o (load_cmd),
    .shift_o    (shift_bit),
    .sample_o   (sample_bit),
    .clr_cnt_o  (clr_cnt),
    .cs_o       (ee_cs_o),
    .sk_o       (ee_sk_o),
    .di_o       (ee_di_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

endmodule

// File: tb/test_mw_word_reader.sv
module test_mw_word_reader;

  localparam int unsigned FREQ   = 125_000_000;
  localparam int unsigned T_SU   = 20;
  localparam int unsigned T_LVL  = 50;
  localparam int          SU_T   = (T_SU  * 125 + 999) / 1000;
  localparam int          LVL_T  = (T_LVL * 125 + 999) / 1000;
  localparam int          LIMIT  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  addr = '0;
  logic        busy, done, cs, sk, di;
  logic [15:0] word;
  logic        ee_do = 1'b0;

  always #4 clk = ~clk;

  mw_word_reader #(
    .CLK_FREQ_HZ(FREQ), .SETUP_NS(T_SU), .LEVEL_NS(T_LVL),
    .ADDR_BITS(6), .DATA_BITS(16)
  ) i_mw_word_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .busy_o(busy), .done_o(done), .word_o(word),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(ee_do)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic timed_out = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] mem_word(input int a);
    return 16'((a * 40503 + 4660) ^ (a << 9) ^ ((a == 63) ? 16'hFFFF : 16'h0));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // responder and protocol monitor
  logic       p_sk = 0, p_cs = 0, p_di = 0;
  int         sk_age = 0, di_age = 0, cs_age = 0;
  int         rise_n = 0, idx = 0;
  logic [8:0] rx_cmd = '0;
  int         v_setup = 0, v_low = 0, v_high = 0, tail_rises = 0, tail_di = 0;

  always @(negedge clk) begin
    if (sk && !p_sk) begin
      if (busy) begin
        if (di != p_di || di_age < SU_T) v_setup++;
        if (cs != p_cs || cs_age < SU_T) v_setup++;
        if (sk_age < LVL_T) v_low++;
      end
      if (cs) begin
        rise_n++;
        if (rise_n <= 9) rx_cmd = {rx_cmd[7:0], di};
        if (rise_n == 9) begin
          idx   = 15;
          ee_do = mem_word(int'(rx_cmd[5:0]))[15];
        end
      end else if (busy) begin
        tail_rises++;
        if (di) tail_di++;
      end
    end
    if (!sk && p_sk) begin
      if (sk_age != LVL_T) v_high++;
      if (cs && rise_n >= 10) begin
        idx--;
        ee_do = (idx >= 0) ? mem_word(int'(rx_cmd[5:0]))[idx] : 1'b0;
      end
    end
    if (!cs) begin
      rise_n = 0;
      ee_do  = 1'b0;
    end
    sk_age = (sk == p_sk) ? sk_age + 1 : 1;
    di_age = (di == p_di) ? di_age + 1 : 1;
    cs_age = (cs == p_cs) ? cs_age + 1 : 1;
    p_sk = sk; p_di = di; p_cs = cs;
  end

  task automatic run_read(input int a, input bit hold);
    @(negedge clk);
    v_setup = 0; v_low = 0; v_high = 0; tail_rises = 0; tail_di = 0;
    start = 1'b1;
    addr  = 6'(a);
    @(negedge clk);
    chk(busy && cs, "R2 busy/cs after start", {busy, cs}, 3);
    if (!hold) start = 1'b0;
    else addr = ~6'(a);
    while (!done && cyc < LIMIT) begin
      @(negedge clk);
      if (!done) begin
        checks++;
        if (!busy) begin
          errors++;
          $display("FAIL R9 busy dropped before done: actual 0 expected 1");
        end
      end
    end
    if (cyc >= LIMIT) begin
      timed_out = 1'b1;
      return;
    end
    chk(word == mem_word(a), "R6 word", word, mem_word(a));
    chk(rx_cmd == {3'b110, 6'(a)}, "R3 opcode+address", rx_cmd, {3'b110, 6'(a)});
    chk(v_setup == 0, "R4 setup violations", v_setup, 0);
    chk(v_low == 0, "R5 low level violations", v_low, 0);
    chk(v_high == 0, "R10 high level length errors", v_high, 0);
    chk(tail_rises == 1 && tail_di == 0, "R7 tail pulses", tail_rises, 1);
    chk(!cs && !sk && !di, "R7 lines low at done", {cs, sk, di}, 0);
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !done, "R8 busy/done after done", {busy, done}, 0);
    @(negedge clk);
    chk(!busy && !cs, "R9 no restart after held start", {busy, cs}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cs && !sk && !di && !busy && !done, "R1 during reset", {cs, sk, di, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cs && !sk && !di && !busy && !done, "R1 after reset", {cs, sk, di, busy, done}, 0);
    for (int a = 0; a < 64 && !timed_out; a++) run_read(a, 1'b0);
    if (!timed_out) run_read(0, 1'b1);
    if (!timed_out) run_read(63, 1'b1);
    if (!timed_out) run_read(21, 1'b1);
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule